// File: doc/BRIEF.md
# Triple-Buffered Block FIR Averager

This block smooths a stream of signed 16-bit fractional samples in fixed-size blocks. Software or an upstream engine writes samples into a circular store of three blocks. Each block-start pulse then makes the block run a 16-tap moving-average filter. Every tap weight is 1/16 in Q15 (0x0800). Each run produces one block of 32 results, which are written out through a simple write port.

The result regions rotate among three 32-word areas of a downstream memory. When a run ends, the block pulses a done flag together with the base address of the region it just filled, so a transmit engine can drain that region while the next run fills another. The very first start pulse after reset only arms the block. It computes nothing, because no full block of input exists at that point.

The multiply-accumulate issues one tap per clock. Each result therefore costs sixteen accumulate cycles plus one write cycle.

Top module: `fir_block_avg`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `res_we` and `blk_done` are low.
- R2: The first `blk_start` pulse after reset produces no result writes and no `blk_done`, and `busy` stays low.
- R3: Every later accepted start produces exactly 32 writes. Their addresses are base+0 to base+31 in ascending order.
- R4: Each result is bits 31:16 of a 40-bit accumulator. The accumulator holds the sum over 16 taps of (sample × 0x0800) shifted left by one and sign-extended. No saturation is applied, and the accumulator wraps.
- R5: In a run whose region index is j (0, 1 or 2), result r uses the samples at store addresses (32·j + r + k) mod 96, for k = 0 to 15. Reads wrap from address 95 to address 0.
- R6: Accepted runs use region bases 0, 32, 64 in that order and then start again at 0. `blk_base` during `blk_done` equals the base of the run just finished.
- R7: After the clock edge that samples an accepted start, result r is written in the cycle after edge 17·r+16. `blk_done` is high for exactly one cycle, after edge 544.
- R8: A `blk_start` that arrives while `busy` is high is ignored. The run in progress and the rotation order are unchanged.
- R9: A sample write to an address of 96 or above changes nothing in the store.
- R10: `busy` goes high after the edge that accepts a start. It stays high through the last write and is low in the cycle in which `blk_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_we | input | 1 | Sample store write enable |
| smp_addr | input | 7 | Sample store write address (0 to 95 valid) |
| smp_data | input | 16 | Signed Q15 sample |
| blk_start | input | 1 | Block start pulse |
| busy | output | 1 | A run is in progress |
| res_we | output | 1 | Result write strobe |
| res_addr | output | 7 | Result write address |
| res_data | output | 16 | Result word |
| blk_done | output | 1 | One-cycle run-complete pulse |
| blk_base | output | 7 | Base of the region just filled, valid with `blk_done` |

## Verification
The edge that samples an accepted start is counted as edge zero. Result r is then due in the cycle after edge 17·r+16, and the done pulse after edge 544. The bench counts clock edges from that sampling edge and reads the outputs at each following falling edge. Every observed write is compared against its index-derived due cycle, its address and a value computed from a model of the sample store. The done pulse must fall on exactly cycle 544 with the expected base.

// File: rtl/fir_blk_pkg.sv
package fir_blk_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_MAC  = 2'd1,
    SEQ_PUT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fir_sample_store.sv
module fir_sample_store #(
  parameter int DEPTH = 96,
  parameter int DW    = 16,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [DEPTH];

  // one write decoder per entry; addresses at or past DEPTH match nothing
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (ent_en) mem_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == AW'(i)) rd_data = mem_q[i];
    end
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int                    DW    = 16,
  parameter int                    ACC_W = 40,
  parameter logic signed [DW-1:0]  COEF  = 16'sh0800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic [DW-1:0] sample,
  output logic [DW-1:0] result
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    prod_fr;
  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    prod     = COEF * $signed(sample);
    prod_fr  = prod <<< 1;
    prod_ext = {{(ACC_W-PW){prod_fr[PW-1]}}, prod_fr};
    acc_d    = acc_q;
    if (en) acc_d = first ? prod_ext : acc_q + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign result = acc_q[PW-1:DW];
endmodule

// File: rtl/fir_seq.sv
module fir_seq
  import fir_blk_pkg::*;
#(
  parameter int TAPS = 16,
  parameter int BLK  = 32,
  parameter int NREG = 3,
  parameter int AW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mac_en,
  output logic          mac_first,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          put,
  output logic [AW-1:0] put_addr,
  output logic          done,
  output logic [AW-1:0] done_base
);
  localparam int DEPTH = NREG * BLK;
  localparam int TW    = $clog2(TAPS);
  localparam int RW    = $clog2(BLK);
  localparam int GW    = (NREG > 1) ? $clog2(NREG) : 1;

  seq_state_e    st_q, st_d;
  logic [TW-1:0] tap_q, tap_d;
  logic [RW-1:0] res_q, res_d;
  logic [AW-1:0] win_q, win_d;
  logic [GW-1:0] reg_q, reg_d;
  logic          armed_q, armed_d;
  logic          done_q, done_d;
  logic [AW-1:0] dbase_q, dbase_d;
  logic [AW-1:0] base;
  logic [AW:0]   rd_sum;
  logic [AW:0]   win_inc;

  assign base = AW'(reg_q) * AW'(BLK);

  always_comb begin
    rd_sum  = {1'b0, win_q} + (AW+1)'(tap_q);
    rd_addr = (rd_sum >= (AW+1)'(DEPTH)) ? AW'(rd_sum - (AW+1)'(DEPTH)) : AW'(rd_sum);
    win_inc = {1'b0, win_q} + 1'b1;
  end

  always_comb begin
    st_d      = st_q;
    tap_d     = tap_q;
    res_d     = res_q;
    win_d     = win_q;
    reg_d     = reg_q;
    armed_d   = armed_q;
    done_d    = 1'b0;
    dbase_d   = dbase_q;
    mac_en    = 1'b0;
    mac_first = 1'b0;
    put       = 1'b0;
    put_addr  = base + AW'(res_q);
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          if (!armed_q) begin
            armed_d = 1'b1;
          end else begin
            st_d  = SEQ_MAC;
            tap_d = '0;
            res_d = '0;
            win_d = base;
          end
        end
      end
      SEQ_MAC: begin
        mac_en    = 1'b1;
        mac_first = (tap_q == '0);
        tap_d     = tap_q + 1'b1;
        if (tap_q == TW'(TAPS - 1)) st_d = SEQ_PUT;
      end
      SEQ_PUT: begin
        put   = 1'b1;
        tap_d = '0;
        win_d = (win_inc >= (AW+1)'(DEPTH)) ? '0 : AW'(win_inc);
        if (res_q == RW'(BLK - 1)) begin
          st_d    = SEQ_IDLE;
          done_d  = 1'b1;
          dbase_d = base;
          reg_d   = (reg_q == GW'(NREG - 1)) ? '0 : reg_q + 1'b1;
        end else begin
          res_d = res_q + 1'b1;
          st_d  = SEQ_MAC;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      tap_q   <= '0;
      res_q   <= '0;
      win_q   <= '0;
      reg_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      dbase_q <= '0;
    end else begin
      st_q    <= st_d;
      tap_q   <= tap_d;
      res_q   <= res_d;
      win_q   <= win_d;
      reg_q   <= reg_d;
      armed_q <= armed_d;
      done_q  <= done_d;
      dbase_q <= dbase_d;
    end
  end

  assign busy      = (st_q != SEQ_IDLE);
  assign done      = done_q;
  assign done_base = dbase_q;
endmodule

// File: rtl/fir_block_avg.sv
module fir_block_avg #(
  parameter int                    DW    = 16,
  parameter int                    TAPS  = 16,
  parameter int                    BLK   = 32,
  parameter int                    NREG  = 3,
  parameter int                    ACC_W = 40,
  parameter logic signed [15:0]    COEF  = 16'sh0800,
  parameter int                    AW    = $clog2(NREG * BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_we,
  input  logic [AW-1:0] smp_addr,
  input  logic [DW-1:0] smp_data,
  input  logic          blk_start,
  output logic          busy,
  output logic          res_we,
  output logic [AW-1:0] res_addr,
  output logic [DW-1:0] res_data,
  output logic          blk_done,
  output logic [AW-1:0] blk_base
);
  localparam int DEPTH = NREG * BLK;

  logic          mac_en, mac_first;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  fir_sample_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) store_i (
    .clk     (clk),
    .wr_en   (smp_we),
    .wr_addr (smp_addr),
    .wr_data (smp_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  fir_mac #(.DW(DW), .ACC_W(ACC_W), .COEF(DW'(COEF))) mac_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mac_en),
    .first  (mac_first),
    .sample (rd_data),
    .result (res_data)
  );

  fir_seq #(.TAPS(TAPS), .BLK(BLK), .NREG(NREG), .AW(AW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (blk_start),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .put       (res_we),
    .put_addr  (res_addr),
    .done      (blk_done),
    .done_base (blk_base)
  );
endmodule

// File: rtl/fir_block_avg_chk.sv
module fir_block_avg_chk #(
  parameter int BLK  = 32,
  parameter int NREG = 3,
  parameter int AW   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          res_we,
  input logic [AW-1:0] res_addr,
  input logic          blk_done,
  input logic [AW-1:0] blk_base
);
  localparam int DEPTH = NREG * BLK;

  logic [AW-1:0] exp_base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_base_q <= '0;
    else if (blk_done)
      exp_base_q <= (exp_base_q == AW'(DEPTH - BLK)) ? '0 : exp_base_q + AW'(BLK);
  end

  a_r3_addr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_addr >= exp_base_q) && (res_addr < exp_base_q + AW'(BLK)));

  a_r7_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> !res_we);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  a_r6_base_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> blk_base == exp_base_q);

  a_r10_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> busy);

  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> blk_done);
endmodule

bind fir_block_avg fir_block_avg_chk #(.BLK(BLK), .NREG(NREG), .AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .res_we   (res_we),
  .res_addr (res_addr),
  .blk_done (blk_done),
  .blk_base (blk_base)
);

// File: tb/fir_block_avg_tb_top.sv
`timescale 1ns/1ps
module fir_block_avg_tb_top;
  localparam int AW = 7;
  localparam int DEPTH = 96;

  logic          clk;
  logic          rst_n;
  logic          smp_we;
  logic [AW-1:0] smp_addr;
  logic [15:0]   smp_data;
  logic          blk_start;
  logic          busy;
  logic          res_we;
  logic [AW-1:0] res_addr;
  logic [15:0]   res_data;
  logic          blk_done;
  logic [AW-1:0] blk_base;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [DEPTH];

  fir_block_avg dut_i (
    .clk(clk), .rst_n(rst_n), .smp_we(smp_we), .smp_addr(smp_addr),
    .smp_data(smp_data), .blk_start(blk_start), .busy(busy),
    .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
    .blk_done(blk_done), .blk_base(blk_base)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] exp_res(input int first);
    logic signed [39:0] acc;
    acc = '0;
    for (int k = 0; k < 16; k++) begin
      acc = acc + ((40'(signed'(model[(first + k) % DEPTH])) * 40'sd2048) <<< 1);
    end
    return acc[31:16];
  endfunction

  task automatic write_smp(input int addr, input logic [15:0] val);
    @(negedge clk);
    smp_we = 1'b1; smp_addr = AW'(addr); smp_data = val;
    @(negedge clk);
    smp_we = 1'b0;
    if (addr < DEPTH) model[addr] = val;
  endtask

  // mode: 0 random, 1 all max, 2 all min, 3 ramp
  task automatic fill(input int mode);
    for (int a = 0; a < DEPTH; a++) begin
      logic [15:0] v;
      case (mode)
        1: v = 16'h7FFF;
        2: v = 16'h8000;
        3: v = 16'(a * 331 - 16000);
        default: v = 16'($urandom);
      endcase
      write_smp(a, v);
    end
  endtask

  // drives one start and observes 560 cycles; region < 0 means expect the trigger to be ignored
  task automatic run_pass(input int region, input bit poke_mid);
    int nw = 0;
    int nd = 0;
    @(negedge clk);
    blk_start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 560; k++) begin
      @(negedge clk);
      blk_start = (poke_mid && k == 200) ? 1'b1 : 1'b0;
      if (k == 0) chk(busy == (region >= 0), "R10 busy after start edge", busy, region >= 0);
      if (res_we) begin
        if (region < 0) chk(1'b0, "R2 write after ignored start", k, -1);
        else begin
          chk(k == 17 * nw + 16, "R7 write timing", k, 17 * nw + 16);
          chk(res_addr == AW'(32 * region + nw), "R3 write address", res_addr, 32 * region + nw);
          chk(res_data == exp_res(32 * region + nw), "R4 R5 result value",
              res_data, exp_res(32 * region + nw));
        end
        nw++;
      end
      if (blk_done) begin
        chk(k == 544, "R7 done timing", k, 544);
        chk(blk_base == AW'(32 * region), "R6 done base", blk_base, 32 * region);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        nd++;
      end
    end
    chk(nw == ((region < 0) ? 0 : 32), "R3 R8 write count", nw, (region < 0) ? 0 : 32);
    chk(nd == ((region < 0) ? 0 : 1), "R2 R7 done count", nd, (region < 0) ? 0 : 1);
    chk(busy == 1'b0, "R10 idle after run", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; smp_we = 1'b0; smp_addr = '0; smp_data = '0; blk_start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !res_we && !blk_done, "R1 outputs low in reset", {busy, res_we, blk_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_we && !blk_done, "R1 outputs low after reset", {busy, res_we, blk_done}, 0);

    fill(0);
    run_pass(-1, 1'b0);             // R2 first trigger only arms
    run_pass(0, 1'b0);              // region 0, random
    fill(1);
    run_pass(1, 1'b1);              // region 1, all max, R8 start mid-run ignored
    fill(3);
    run_pass(2, 1'b0);              // region 2, ramp, R5 wrap past 95
    fill(0);
    write_smp(96, 16'h1234);        // R9 out-of-range writes ignored
    write_smp(127, 16'hBEEF);
    run_pass(0, 1'b0);              // R6 rotation back to 0
    fill(2);
    run_pass(1, 1'b0);              // all min
    fill(0);
    run_pass(2, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule